// File: doc/BRIEF.md
# Slave-Serial Configuration Loader

This block loads a configuration bitstream into a programmable target device over a serial link. The link has one clock pin and one data pin. An active-low program pin resets the target. The target reports back on two status pins: an active-low INIT and an active-high DONE. A host pulses `start` and supplies the total byte count. It then feeds the bytes through a valid/ready stream. The loader first resets the target and waits for it to report ready. It then shifts every byte out and keeps clocking until the target signals completion.

Every pin change is separated by a programmable pacing interval, counted in system clock cycles. The pacing interval, the byte count and the three timeouts are captured when `start` is accepted. Each of the three waits for the target has its own timeout counter. These waits are: INIT going active after program is asserted, INIT going inactive after program is released, and DONE going high after the data ends. The INIT and DONE inputs pass through a two-flop synchronizer before the sequencer uses them.

The sequencer states are:

- IDLE: waiting for start.
- PROG: program asserted, waiting for INIT.
- PGAP: one pacing interval with program still low.
- RELEASE: program released, waiting for INIT to clear.
- CHECK: per-byte error check and end-of-data test.
- FETCH: waiting for a byte on the stream.
- BLOW, BDATA, BHIGH: clock low, data driven, clock high.
- PCHECK: DONE test.
- PLOW, PHIGH: the post-load clock pulses.

The transitions are:

- IDLE→PROG on start.
- PROG→PGAP on INIT active, or PROG→IDLE on timeout.
- PGAP→RELEASE after one pacing interval.
- RELEASE→CHECK on INIT inactive, or RELEASE→IDLE on timeout.
- CHECK→IDLE on error, CHECK→PCHECK when no bytes remain, otherwise CHECK→FETCH.
- FETCH→BLOW on a handshake.
- BLOW→BDATA and BDATA→BHIGH, each after one interval.
- BHIGH→BLOW after one interval, or BHIGH→CHECK after the eighth bit.
- PCHECK→IDLE on DONE or on timeout, otherwise PCHECK→PLOW.
- PLOW→PHIGH and PHIGH→PCHECK, each after one interval.

Top module: `cfg_serial_loader`

## Requirements
- R1: After reset the outputs are `tgt_prog_n`=1, `tgt_cclk`=0, `tgt_din`=1, `busy`=0, `in_ready`=0, and all three status flags are 0.
- R2: On an accepted start, `tgt_prog_n` is driven 0 and held there until INIT (`tgt_init_n`=0) is seen. If INIT is not seen within `init_timeout` cycles, the load ends with `err_timeout`=1 and no bit is clocked.
- R3: After INIT is seen, program stays low for one more pacing interval and is then released. INIT must return high within `release_timeout` cycles, or the load ends with `err_timeout`=1 and no bit is clocked.
- R4: Every byte is sent as exactly 8 bits, most significant bit first. The target samples each bit on the rising edge of `tgt_cclk`.
- R5: Each bit is sent in three steps: clock low, then data driven, then clock high. Each step lasts `max(delay_cycles,1)` system cycles, so a high phase of `tgt_cclk` lasts exactly that many cycles.
- R6: Before each byte, if DONE is low while INIT is active, the load stops with `err_crc`=1. No further byte is taken from the stream.
- R7: When all bytes are sent, `tgt_din` is held at 1 and `tgt_cclk` keeps pulsing until DONE is high. The load then ends with `done_ok`=1. A byte count of 0 goes straight to this phase.
- R8: If DONE does not rise within `done_timeout` cycles of the post-load phase, the load ends with `err_timeout`=1.
- R9: At most one status flag is set. The flags stay latched after `busy` falls and are cleared on the next accepted start. `done_ok` is set only after DONE is observed.
- R10: A `start` pulse while `busy`=1 is ignored, and the running load completes unchanged.
- R11: `in_ready` is high only while the loader waits for a byte. Exactly `byte_count` bytes are consumed on a successful load, one per valid/ready handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a load (accepted only when idle) |
| byte_count | input | CNT_W | Number of bitstream bytes |
| delay_cycles | input | DLY_W | Pacing interval between pin changes (0 acts as 1) |
| init_timeout | input | TO_W | Cycle limit for INIT to go active |
| release_timeout | input | TO_W | Cycle limit for INIT to go inactive |
| done_timeout | input | TO_W | Cycle limit for DONE in post-load clocking |
| in_data | input | 8 | Stream byte |
| in_valid | input | 1 | Stream byte valid |
| in_ready | output | 1 | Loader takes the byte this cycle if valid |
| tgt_prog_n | output | 1 | Program pin to target, active low |
| tgt_cclk | output | 1 | Configuration clock to target |
| tgt_din | output | 1 | Serial data to target |
| tgt_init_n | input | 1 | INIT status from target, active low |
| tgt_done | input | 1 | DONE status from target |
| busy | output | 1 | A load is in progress |
| done_ok | output | 1 | Last load succeeded |
| err_crc | output | 1 | Last load stopped on a target-reported error |
| err_timeout | output | 1 | Last load timed out on a wait |

## Verification
The hardest condition to reach is the error check between bytes. It requires INIT to drop while DONE is still low, after some bytes have gone out but before the stream ends. The bench's target model counts the rising edges of `tgt_cclk`. After the second byte it pulls INIT low on its own, so the next per-byte check sees the fault while later bytes are still pending. The release timeout needs a target that answers the reset but never lets INIT go again. The model has a separate switch that produces exactly that.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PROG,
        ST_PGAP,
        ST_RELEASE,
        ST_CHECK,
        ST_FETCH,
        ST_BLOW,
        ST_BDATA,
        ST_BHIGH,
        ST_PCHECK,
        ST_PLOW,
        ST_PHIGH
    } ld_state_e;

    localparam int NUM_WAITS = 3;
    localparam int WAIT_INIT = 0;
    localparam int WAIT_REL  = 1;
    localparam int WAIT_DONE = 2;

endpackage

// File: rtl/cfg_sync2.sv
module cfg_sync2 #(
    parameter int         W       = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic s1, s2;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1 <= RST_VAL[i];
                s2 <= RST_VAL[i];
            end else begin
                s1 <= d[i];
                s2 <= s1;
            end
        end
        assign q[i] = s2;
    end
endmodule

// File: rtl/cfg_pace_timer.sv
module cfg_pace_timer #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [DW-1:0] limit,
    output logic          tick
);
    localparam logic [DW-1:0] ONE = DW'(1);

    logic [DW-1:0] cnt;
    logic [DW-1:0] last;

    // an interval of 0 behaves as 1 cycle
    assign last = (limit == '0) ? '0 : limit - ONE;
    assign tick = run && (cnt == last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + ONE;
        end
    end

    // R5: the count never passes the end of its interval
    assert_pace_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        run && $stable(limit) |-> cnt <= last);
endmodule

// File: rtl/cfg_wait_timer.sv
module cfg_wait_timer #(
    parameter int TW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [TW-1:0] limit,
    output logic          expired
);
    localparam logic [TW-1:0] ONE = TW'(1);

    logic [TW-1:0] cnt;

    assign expired = run && (cnt >= limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (cnt != '1) begin
            cnt <= cnt + ONE;
        end
    end

    // R8: a fresh wait never starts out expired unless its limit is zero
    assert_wait_fresh_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) && limit != '0 |-> !expired);
endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
    import cfg_loader_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int DLY_W = 8,
    parameter int TO_W  = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] byte_count,
    input  logic [DLY_W-1:0] delay_cycles,
    input  logic [TO_W-1:0]  init_timeout,
    input  logic [TO_W-1:0]  release_timeout,
    input  logic [TO_W-1:0]  done_timeout,
    input  logic [7:0]       in_data,
    input  logic             in_valid,
    output logic             in_ready,
    output logic             tgt_prog_n,
    output logic             tgt_cclk,
    output logic             tgt_din,
    input  logic             tgt_init_n,
    input  logic             tgt_done,
    output logic             busy,
    output logic             done_ok,
    output logic             err_crc,
    output logic             err_timeout
);
    localparam int               BIT_W    = 3;
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(7);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    ld_state_e state, state_nx;

    // synchronized target status
    logic [1:0] stat_raw, stat_s;
    logic       init_act, done_s;

    assign stat_raw = {tgt_done, tgt_init_n};

    cfg_sync2 #(.W(2), .RST_VAL(2'b01)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (stat_raw),
        .q     (stat_s)
    );

    assign init_act = !stat_s[0];
    assign done_s   = stat_s[1];

    // captured load parameters
    logic [DLY_W-1:0] delay_q;
    logic [TO_W-1:0]  lim_q [NUM_WAITS];
    logic [CNT_W-1:0] remain_q;
    logic [7:0]       shreg;
    logic [BIT_W-1:0] bit_q;

    // pacing
    logic pace_run, pace_tick;

    assign pace_run = (state == ST_PGAP)  || (state == ST_BLOW)  ||
                      (state == ST_BDATA) || (state == ST_BHIGH) ||
                      (state == ST_PLOW)  || (state == ST_PHIGH);

    cfg_pace_timer #(.DW(DLY_W)) u_pace (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (pace_run),
        .limit (delay_q),
        .tick  (pace_tick)
    );

    // one timeout counter per wait
    logic [NUM_WAITS-1:0] wait_run, wait_exp;

    assign wait_run[WAIT_INIT] = (state == ST_PROG);
    assign wait_run[WAIT_REL]  = (state == ST_RELEASE);
    assign wait_run[WAIT_DONE] = (state == ST_PCHECK) || (state == ST_PLOW) ||
                                 (state == ST_PHIGH);

    for (genvar g = 0; g < NUM_WAITS; g++) begin : g_wait
        cfg_wait_timer #(.TW(TO_W)) u_wait (
            .clk     (clk),
            .rst_n   (rst_n),
            .run     (wait_run[g]),
            .limit   (lim_q[g]),
            .expired (wait_exp[g])
        );
    end

    // stream handshake
    logic take;
    assign in_ready = (state == ST_FETCH);
    assign take     = in_ready && in_valid;

    // completion events
    logic fin_ok, fin_crc, fin_to;
    logic accept;

    assign accept = (state == ST_IDLE) && start;

    // next-state logic
    always_comb begin
        state_nx = state;
        fin_ok   = 1'b0;
        fin_crc  = 1'b0;
        fin_to   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start) state_nx = ST_PROG;
            end
            ST_PROG: begin
                if (init_act) begin
                    state_nx = ST_PGAP;
                end else if (wait_exp[WAIT_INIT]) begin
                    state_nx = ST_IDLE;
                    fin_to   = 1'b1;
                end
            end
            ST_PGAP: begin
                if (pace_tick) state_nx = ST_RELEASE;
            end
            ST_RELEASE: begin
                if (!init_act) begin
                    state_nx = ST_CHECK;
                end else if (wait_exp[WAIT_REL]) begin
                    state_nx = ST_IDLE;
                    fin_to   = 1'b1;
                end
            end
            ST_CHECK: begin
                if (!done_s && init_act) begin
                    state_nx = ST_IDLE;
                    fin_crc  = 1'b1;
                end else if (remain_q == '0) begin
                    state_nx = ST_PCHECK;
                end else begin
                    state_nx = ST_FETCH;
                end
            end
            ST_FETCH: begin
                if (in_valid) state_nx = ST_BLOW;
            end
            ST_BLOW: begin
                if (pace_tick) state_nx = ST_BDATA;
            end
            ST_BDATA: begin
                if (pace_tick) state_nx = ST_BHIGH;
            end
            ST_BHIGH: begin
                if (pace_tick) state_nx = (bit_q == LAST_BIT) ? ST_CHECK : ST_BLOW;
            end
            ST_PCHECK: begin
                if (done_s) begin
                    state_nx = ST_IDLE;
                    fin_ok   = 1'b1;
                end else if (wait_exp[WAIT_DONE]) begin
                    state_nx = ST_IDLE;
                    fin_to   = 1'b1;
                end else begin
                    state_nx = ST_PLOW;
                end
            end
            ST_PLOW: begin
                if (pace_tick) state_nx = ST_PHIGH;
            end
            ST_PHIGH: begin
                if (pace_tick) state_nx = ST_PCHECK;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // datapath and status
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            delay_q     <= '0;
            remain_q    <= '0;
            shreg       <= '0;
            bit_q       <= '0;
            done_ok     <= 1'b0;
            err_crc     <= 1'b0;
            err_timeout <= 1'b0;
            for (int k = 0; k < NUM_WAITS; k++) lim_q[k] <= '0;
        end else begin
            if (accept) begin
                delay_q          <= delay_cycles;
                remain_q         <= byte_count;
                lim_q[WAIT_INIT] <= init_timeout;
                lim_q[WAIT_REL]  <= release_timeout;
                lim_q[WAIT_DONE] <= done_timeout;
                done_ok          <= 1'b0;
                err_crc          <= 1'b0;
                err_timeout      <= 1'b0;
            end
            if (take) begin
                shreg    <= in_data;
                remain_q <= remain_q - CNT_ONE;
                bit_q    <= '0;
            end else if (state == ST_BHIGH && pace_tick) begin
                shreg <= {shreg[6:0], 1'b0};
                bit_q <= bit_q + BIT_W'(1);
            end
            if (fin_ok)  done_ok     <= 1'b1;
            if (fin_crc) err_crc     <= 1'b1;
            if (fin_to)  err_timeout <= 1'b1;
        end
    end

    // registered pin outputs, decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgt_prog_n <= 1'b1;
            tgt_cclk   <= 1'b0;
            tgt_din    <= 1'b1;
            busy       <= 1'b0;
        end else begin
            tgt_prog_n <= !(state_nx == ST_PROG || state_nx == ST_PGAP);
            tgt_cclk   <= (state_nx == ST_BHIGH) || (state_nx == ST_PHIGH);
            busy       <= (state_nx != ST_IDLE);
            if (state_nx == ST_BDATA) begin
                tgt_din <= shreg[7];
            end else if (state_nx == ST_IDLE || state_nx == ST_PCHECK ||
                         state_nx == ST_PLOW || state_nx == ST_PHIGH) begin
                tgt_din <= 1'b1;
            end
        end
    end

    // R9: status flags are mutually exclusive
    assert_status_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done_ok, err_crc, err_timeout}));

    // R9: every finished load leaves a result
    assert_end_has_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (done_ok || err_crc || err_timeout));

    // R9: success only after DONE was seen
    assert_ok_after_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_ok) |-> $past(done_s));

    // R11: bytes are accepted only mid-load with program released
    assert_ready_window_R11: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (busy && tgt_prog_n));

    // R5: data is stable while the clock is high
    assert_din_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_cclk && $past(tgt_cclk) |-> $stable(tgt_din));

    // R2: no configuration clock while program is asserted
    assert_no_clk_in_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !tgt_prog_n |-> !tgt_cclk);
endmodule

// File: tb/sim_cfg_serial_loader.sv
module sim_cfg_serial_loader;
    localparam int CLK_PER = 10;
    localparam int CNT_W = 16;
    localparam int DLY_W = 8;
    localparam int TO_W  = 20;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [CNT_W-1:0] byte_count = '0;
    logic [DLY_W-1:0] delay_cycles = '0;
    logic [TO_W-1:0]  init_timeout = TO_W'(50);
    logic [TO_W-1:0]  release_timeout = TO_W'(50);
    logic [TO_W-1:0]  done_timeout = TO_W'(300);
    logic [7:0]       in_data = '0;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic             tgt_prog_n, tgt_cclk, tgt_din;
    logic             tgt_init_n = 1'b1;
    logic             tgt_done = 1'b0;
    logic             busy, done_ok, err_crc, err_timeout;

    int checks = 0;
    int failures = 0;

    always #(CLK_PER/2) clk = ~clk;

    cfg_serial_loader #(.CNT_W(CNT_W), .DLY_W(DLY_W), .TO_W(TO_W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .byte_count(byte_count),
        .delay_cycles(delay_cycles), .init_timeout(init_timeout),
        .release_timeout(release_timeout), .done_timeout(done_timeout),
        .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .tgt_prog_n(tgt_prog_n), .tgt_cclk(tgt_cclk), .tgt_din(tgt_din),
        .tgt_init_n(tgt_init_n), .tgt_done(tgt_done), .busy(busy),
        .done_ok(done_ok), .err_crc(err_crc), .err_timeout(err_timeout)
    );

    // stimulus and target model state
    logic [7:0] src_mem [8];
    int         src_n = 0;
    int         src_idx = 0;
    bit         m_init_en = 1'b1;
    bit         m_rel_en = 1'b1;
    bit         m_done_en = 1'b1;
    bit         m_crc_mode = 1'b0;
    bit         crc_force = 1'b0;
    int         pcnt = 0;
    int         rcnt = 0;
    int         bits = 0;
    logic [7:0] cap_byte = '0;
    logic [7:0] cap_mem [8];
    int         hcnt = 0;
    int         last_w = 0;

    task automatic check(input string req, input int act, input int exp, input string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // byte source
    always @(posedge clk) if (in_valid && in_ready) src_idx <= src_idx + 1;
    always @(negedge clk) begin
        in_valid = (src_idx < src_n);
        in_data  = (src_idx < src_n) ? src_mem[src_idx[2:0]] : 8'h00;
    end

    // target: INIT behaviour
    always @(posedge clk) begin
        if (!tgt_prog_n) begin
            rcnt <= 0;
            if (m_init_en) begin
                if (pcnt < 3) pcnt <= pcnt + 1;
                else tgt_init_n <= 1'b0;
            end
        end else begin
            pcnt <= 0;
            if (crc_force) begin
                tgt_init_n <= 1'b0;
            end else if (m_rel_en && !tgt_init_n) begin
                if (rcnt < 3) rcnt <= rcnt + 1;
                else tgt_init_n <= 1'b1;
            end
        end
    end

    // target: bit capture and DONE
    always @(posedge tgt_cclk) begin
        if (bits < 8 * src_n) begin
            cap_byte = {cap_byte[6:0], tgt_din};
            if (bits % 8 == 7) cap_mem[(bits / 8) % 8] = cap_byte;
        end
        bits = bits + 1;
        if (m_crc_mode && bits == 16) crc_force = 1'b1;
        if (m_done_en && bits >= 8 * src_n + 4) tgt_done = 1'b1;
    end

    // clock high width measurement
    always @(negedge clk) begin
        if (tgt_cclk) hcnt++;
        else if (hcnt > 0) begin
            last_w = hcnt;
            hcnt = 0;
        end
    end

    task automatic setup(input int n, input int dly, input bit ie, input bit re,
                         input bit de, input bit cm);
        @(negedge clk);
        src_n = n;
        src_idx = 0;
        bits = 0;
        crc_force = 1'b0;
        tgt_done = 1'b0;
        tgt_init_n = 1'b1;
        m_init_en = ie;
        m_rel_en = re;
        m_done_en = de;
        m_crc_mode = cm;
        last_w = 0;
        byte_count = CNT_W'(n);
        delay_cycles = DLY_W'(dly);
        repeat (4) @(negedge clk);
    endtask

    task automatic run_start;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R9: status cleared by the accepted start
        check("R9", {29'd0, done_ok, err_crc, err_timeout}, 0, "status cleared on start");
        check("R9", int'(busy), 1, "busy after start");
    endtask

    task automatic wait_idle;
        for (int c = 0; c < 20000 && busy; c++) @(negedge clk);
    endtask

    task automatic t_reset;
        check("R1", int'(tgt_prog_n), 1, "prog_n at reset");
        check("R1", int'(tgt_cclk), 0, "cclk at reset");
        check("R1", int'(tgt_din), 1, "din at reset");
        check("R1", int'(busy), 0, "busy at reset");
        check("R1", int'(in_ready), 0, "in_ready at reset");
        check("R1", {29'd0, done_ok, err_crc, err_timeout}, 0, "status at reset");
    endtask

    task automatic t_normal(input int dly);
        int n;
        n = 4;
        src_mem[0] = 8'hA5; src_mem[1] = 8'h3C; src_mem[2] = 8'hF0; src_mem[3] = 8'h01;
        setup(n, dly, 1, 1, 1, 0);
        run_start();
        // R2: program asserted before INIT answers
        check("R2", int'(tgt_prog_n), 0, "prog_n asserted after start");
        wait_idle();
        check("R7", int'(done_ok), 1, "done_ok after DONE");
        check("R11", src_idx, n, "bytes consumed");
        for (int i = 0; i < n; i++)
            check("R4", int'(cap_mem[i]), int'(src_mem[i]), "captured byte MSB first");
        check("R5", last_w, (dly == 0) ? 1 : dly, "cclk high width");
        check("R7", int'(bits > 8 * n), 1, "post-load pulses issued");
        repeat (20) @(negedge clk);
        check("R9", int'(done_ok), 1, "done_ok stays latched");
    endtask

    task automatic t_pattern0;
        src_mem[0] = 8'h80; src_mem[1] = 8'h7F; src_mem[2] = 8'h55;
        setup(3, 0, 1, 1, 1, 0);
        run_start();
        wait_idle();
        check("R7", int'(done_ok), 1, "done_ok with zero delay");
        for (int i = 0; i < 3; i++)
            check("R4", int'(cap_mem[i]), int'(src_mem[i]), "byte with zero delay");
        check("R5", last_w, 1, "zero delay acts as one cycle");
    endtask

    task automatic t_empty;
        setup(0, 2, 1, 1, 1, 0);
        run_start();
        wait_idle();
        check("R7", int'(done_ok), 1, "zero bytes still succeeds");
        check("R11", src_idx, 0, "no byte taken for zero count");
    endtask

    task automatic t_crc;
        for (int i = 0; i < 6; i++) src_mem[i] = 8'(8'h11 * (i + 1));
        setup(6, 1, 1, 1, 0, 1);
        run_start();
        wait_idle();
        check("R6", int'(err_crc), 1, "err_crc flagged");
        check("R6", int'(done_ok), 0, "no success on error");
        check("R6", int'(src_idx < 6), 1, "stream stopped early");
        check("R6", int'(in_ready), 0, "no byte requested after error");
    endtask

    task automatic t_init_to;
        src_mem[0] = 8'hC3;
        setup(1, 1, 0, 1, 1, 0);
        run_start();
        wait_idle();
        check("R2", int'(err_timeout), 1, "INIT timeout");
        check("R2", bits, 0, "no clock on INIT timeout");
        check("R2", int'(tgt_prog_n), 1, "prog released after timeout");
    endtask

    task automatic t_rel_to;
        src_mem[0] = 8'hC3;
        setup(1, 1, 1, 0, 1, 0);
        run_start();
        wait_idle();
        check("R3", int'(err_timeout), 1, "INIT release timeout");
        check("R3", bits, 0, "no clock on release timeout");
    endtask

    task automatic t_done_to;
        src_mem[0] = 8'h5A; src_mem[1] = 8'hA5;
        setup(2, 1, 1, 1, 0, 0);
        run_start();
        wait_idle();
        check("R8", int'(err_timeout), 1, "DONE timeout");
        check("R8", int'(done_ok), 0, "no success without DONE");
        check("R8", int'(cap_mem[1]), 8'hA5, "data still sent before timeout");
    endtask

    task automatic t_busy_start;
        src_mem[0] = 8'h12; src_mem[1] = 8'h34; src_mem[2] = 8'h56;
        setup(3, 2, 1, 1, 1, 0);
        run_start();
        repeat (40) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R10", int'(busy), 1, "still busy after ignored start");
        wait_idle();
        check("R10", int'(done_ok), 1, "load completes after ignored start");
        check("R10", src_idx, 3, "byte count unchanged");
        check("R10", int'(cap_mem[2]), 8'h56, "last byte intact");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_normal(2);
        t_normal(3);
        t_pattern0();
        t_empty();
        t_crc();
        t_init_to();
        t_rel_to();
        t_done_to();
        t_busy_start();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule